// File: doc/BRIEF.md
# Tagless Loop Instruction Buffer

This block sits in the instruction fetch path, between the core's fetch stage and a larger main instruction cache. When the core runs a short loop, the block captures the loop body in a small direct-mapped word array. It then returns every later iteration from that array, and the main cache stays disabled for those fetches. The array has no address tags. A controller tracks the loop start, the loop length and the next address the loop will fetch. For each fetch it therefore knows, from its registered state, which source will answer, and it never needs a lookup.

The core marks a loop by raising a loop-detect pulse with the loop start address and the body length in words. The pulse is raised together with the fetch of the loop start, which is the target of the backward branch. The first such pulse opens a fill pass: the body is fetched from the main cache and copied into the array. A second pulse for the same loop, arriving on the loop-back fetch, switches the controller to serving from the array. Any fetch that leaves the loop drops the controller back to idle. Both sources answer one cycle after the request, so switching sources never changes fetch timing.

Top module: `tagless_loop_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_rvalid` and `mc_en` are low, and the first fetch after reset goes to the main cache.
- R2: Every fetch (a cycle with `fetch_req` high) gets `fetch_rvalid` high exactly one cycle later. `fetch_rdata` then equals the memory word at the requested address, whichever source served it.
- R3: With no loop captured, every fetch drives `mc_en` high and sets `mc_addr` to the fetch address in the same cycle.
- R4: A qualifying detect opens a fill pass. A detect qualifies when `loop_det` is high on a fetch whose address equals `loop_start`, with `loop_len` between 1 and DEPTH. That fetch and the following in-order body fetches go to the main cache, and each returned word is stored at array slot `addr[6:2]` (for DEPTH 32).
- R5: During a fill pass, a detect with the same start and length that arrives on the loop-back fetch (the start address, after the last body word) makes the controller serve from the array. That detect fetch itself is still served by the main cache.
- R6: While serving from the array, a fetch of the expected next word is answered from the array and `mc_en` stays low. The expected next word is the following address, or the loop start after the last word.
- R7: In a fill pass or while serving, a fetch of any address other than the expected one is sent to the main cache and returns the controller to idle, so later fetches also go to the main cache.
- R8: A detect whose length is 0 or above DEPTH returns the controller to idle. A detect raised on a fetch whose address differs from `loop_start` is ignored.
- R9: A qualifying detect for a different start or length, raised during a fill pass or while serving, starts a new fill pass for the new loop. The new loop's words overwrite the array slots it maps to.
- R10: Cycles without a fetch produce no response and leave the controller state unchanged.
- R11: Loops of length 1 and of length DEPTH are captured and replayed correctly, and a DEPTH-word loop may start at any array slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core fetch request this cycle |
| fetch_addr | input | ADDR_W | Word-aligned fetch address |
| fetch_rvalid | output | 1 | Fetched word valid (one cycle after request) |
| fetch_rdata | output | DATA_W | Fetched instruction word |
| mc_en | output | 1 | Main cache fetch enable |
| mc_addr | output | ADDR_W | Main cache fetch address |
| mc_rdata | input | DATA_W | Main cache word, one cycle after `mc_en` |
| loop_det | input | 1 | Loop-detect pulse, raised with the loop-start fetch |
| loop_start | input | ADDR_W | Loop start address carried by the detect |
| loop_len | input | $clog2(DEPTH)+1 | Loop body length in words |

## Verification
The choice of source is combinational from registered state, so `mc_en` and `mc_addr` are checked shortly after the inputs are driven in the request cycle. The returned word arrives one clock later from either source, and the bench samples `fetch_rvalid` and `fetch_rdata` on the following falling edge. Each state change takes effect on the fetch that follows the one that caused it, so each directed task predicts the source for every fetch in its sequence. Data is compared against a memory function that the bench computes independently.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    LB_IDLE   = 2'd0,
    LB_FILL   = 2'd1,
    LB_ACTIVE = 2'd2
  } lb_state_e;

endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // write port: fill words arriving from the main cache
  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  // read port: registered so it lines up with the main cache latency
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= words[rd_idx];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 32,
  parameter int LEN_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              det,
  input  logic [ADDR_W-1:0] det_start,
  input  logic [LEN_W-1:0]  det_len,
  output logic              buf_hit,
  output logic              fill_en,
  output logic              active_o,
  output logic [ADDR_W-1:0] exp_addr_o
);

  localparam int POS_W = $clog2(DEPTH);

  // ---- arithmetic helpers ----
  function automatic logic len_fits(input logic [LEN_W-1:0] n);
    return (n != '0) && (n <= LEN_W'(DEPTH));
  endfunction

  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(4);
  endfunction

  function automatic logic at_last(input logic [POS_W-1:0] p, input logic [LEN_W-1:0] n);
    return (LEN_W'(p) + LEN_W'(1)) == n;
  endfunction

  // ---- state ----
  lb_state_e         state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic [POS_W-1:0]  pos_q;
  logic [ADDR_W-1:0] exp_q;

  // ---- named events ----
  logic det_here, det_ok, det_bad;
  logic tracking, on_track, same_loop, keep;
  logic restart, advance, abort, go_active, active_w;

  assign det_here  = det && req_valid && (req_addr == det_start);
  assign det_ok    = det_here && len_fits(det_len);
  assign det_bad   = det_here && !len_fits(det_len);
  assign tracking  = (state_q != LB_IDLE);
  assign on_track  = (req_addr == exp_q);
  assign same_loop = (det_start == start_q) && (det_len == len_q);
  assign keep      = tracking && on_track && same_loop;
  assign restart   = det_ok && !keep;
  assign advance   = req_valid && tracking && on_track && !det_bad && !restart;
  assign abort     = req_valid && tracking && !on_track && !det_here;
  assign go_active = advance && det_ok && (state_q == LB_FILL);
  assign active_w  = (state_q == LB_ACTIVE);

  assign buf_hit    = advance && active_w;
  assign fill_en    = restart || (advance && (state_q == LB_FILL));
  assign active_o   = active_w;
  assign exp_addr_o = exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LB_IDLE;
      start_q <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      exp_q   <= '0;
    end else if (det_bad || abort) begin
      state_q <= LB_IDLE;
    end else if (restart) begin
      state_q <= LB_FILL;
      start_q <= det_start;
      len_q   <= det_len;
      if (at_last('0, det_len)) begin
        pos_q <= '0;
        exp_q <= det_start;
      end else begin
        pos_q <= POS_W'(1);
        exp_q <= next_word(det_start);
      end
    end else if (advance) begin
      if (go_active) state_q <= LB_ACTIVE;
      if (at_last(pos_q, len_q)) begin
        pos_q <= '0;
        exp_q <= start_q;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        exp_q <= next_word(exp_q);
      end
    end
  end

  // R5
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && !$past(active_w)) |-> $past(state_q == LB_FILL));

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state_q == LB_IDLE));

  // R8
  len_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_bad |=> (state_q == LB_IDLE));

endmodule

// File: rtl/tagless_loop_buf.sv
module tagless_loop_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LEN_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_rvalid,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              mc_en,
  output logic [ADDR_W-1:0] mc_addr,
  input  logic [DATA_W-1:0] mc_rdata,
  input  logic              loop_det,
  input  logic [ADDR_W-1:0] loop_start,
  input  logic [LEN_W-1:0]  loop_len
);

  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W+1:2];
  endfunction

  logic              buf_hit, fill_en, active_w;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] arr_rdata;

  logic              rvalid_q, from_buf_q, fill_q;
  logic [IDX_W-1:0]  fill_idx_q;

  tlb_ctrl #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .LEN_W  (LEN_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (fetch_req),
    .req_addr   (fetch_addr),
    .det        (loop_det),
    .det_start  (loop_start),
    .det_len    (loop_len),
    .buf_hit    (buf_hit),
    .fill_en    (fill_en),
    .active_o   (active_w),
    .exp_addr_o (exp_addr)
  );

  tlb_array #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) array_i (
    .clk     (clk),
    .rd_en   (buf_hit),
    .rd_idx  (slot_of(fetch_addr)),
    .wr_en   (fill_q),
    .wr_idx  (fill_idx_q),
    .wr_data (mc_rdata),
    .rd_data (arr_rdata)
  );

  // main cache request path: active whenever the array will not answer
  assign mc_en   = fetch_req && !buf_hit;
  assign mc_addr = fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      from_buf_q <= 1'b0;
      fill_q     <= 1'b0;
      fill_idx_q <= '0;
    end else begin
      rvalid_q   <= fetch_req;
      from_buf_q <= buf_hit;
      fill_q     <= fill_en;
      fill_idx_q <= slot_of(fetch_addr);
    end
  end

  assign fetch_rvalid = rvalid_q;
  assign fetch_rdata  = from_buf_q ? arr_rdata : mc_rdata;

  // R2
  resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> fetch_rvalid);

  // R6
  mc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && fetch_req && !loop_det && (fetch_addr == exp_addr)) |-> !mc_en);

  // R4
  fill_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> !from_buf_q);

endmodule

// File: tb/tagless_loop_buf_tb_top.sv
module tagless_loop_buf_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_rvalid;
  logic [31:0] fetch_rdata;
  logic        mc_en;
  logic [31:0] mc_addr;
  logic [31:0] mc_rdata = '0;
  logic        loop_det;
  logic [31:0] loop_start;
  logic [5:0]  loop_len;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tagless_loop_buf dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .fetch_rvalid (fetch_rvalid),
    .fetch_rdata  (fetch_rdata),
    .mc_en        (mc_en),
    .mc_addr      (mc_addr),
    .mc_rdata     (mc_rdata),
    .loop_det     (loop_det),
    .loop_start   (loop_start),
    .loop_len     (loop_len)
  );

  // reference program memory
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[17:2]};
  endfunction

  // main cache model: one cycle latency
  always @(posedge clk) if (mc_en) mc_rdata <= mem_word(mc_addr);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one fetch; called at a falling edge, returns at the next falling edge
  task automatic fetch(input logic [31:0] a, input bit want_buf, input string rq,
                       input bit d, input logic [31:0] ds, input logic [5:0] dl);
    fetch_req  = 1'b1;
    fetch_addr = a;
    loop_det   = d;
    loop_start = ds;
    loop_len   = dl;
    #1;
    if (want_buf)
      chk(mc_en === 1'b0, rq, "cache enable while served from array", {31'b0, mc_en}, 32'h0);
    else
      chk(mc_en === 1'b1 && mc_addr === a, rq, "cache request address",
          mc_en ? mc_addr : 32'hFFFF_FFFF, a);
    @(negedge clk);
    chk(fetch_rvalid === 1'b1 && fetch_rdata === mem_word(a), rq, "returned word",
        fetch_rvalid ? fetch_rdata : 32'hDEAD_0000, mem_word(a));
    fetch_req = 1'b0;
    loop_det  = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(fetch_rvalid === 1'b0 && mc_en === 1'b0, "R10", "no response without fetch",
          {30'b0, fetch_rvalid, mc_en}, 32'h0);
    end
  endtask

  // fill pass, switch to array, further iterations from the array
  task automatic run_loop(input logic [31:0] s, input int len, input int iters,
                          input int gap_n, input string rq);
    fetch(s, 0, "R4", 1, s, 6'(len));
    for (int k = 1; k < len; k++) fetch(s + 32'(4 * k), 0, "R4", 0, 0, 0);
    fetch(s, 0, "R5", 1, s, 6'(len));
    for (int k = 1; k < len; k++) fetch(s + 32'(4 * k), 1, rq, 0, 0, 0);
    for (int it = 1; it < iters; it++) begin
      if (gap_n > 0) gap(gap_n);
      for (int k = 0; k < len; k++) fetch(s + 32'(4 * k), 1, rq, k == 0, s, 6'(len));
    end
  endtask

  task automatic leave_loop(input logic [31:0] s);
    fetch(32'h0009_0000, 0, "R7", 0, 0, 0);
    fetch(32'h0009_0004, 0, "R7", 0, 0, 0);
    fetch(s, 0, "R7", 0, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0; loop_det = 1'b0;
    loop_start = '0; loop_len = '0;
    repeat (3) @(negedge clk);
    chk(fetch_rvalid === 1'b0 && mc_en === 1'b0, "R1", "outputs in reset",
        {30'b0, fetch_rvalid, mc_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_rvalid === 1'b0, "R1", "no response after reset", {31'b0, fetch_rvalid}, 32'h0);
    fetch(32'h0000_0100, 0, "R1", 0, 0, 0);
  endtask

  task automatic t_idle();
    fetch(32'h0000_2000, 0, "R3", 0, 0, 0);
    fetch(32'h0000_2004, 0, "R3", 0, 0, 0);
    fetch(32'h0000_0040, 0, "R3", 0, 0, 0);
  endtask

  task automatic t_basic();
    run_loop(32'h1000_0040, 5, 3, 2, "R6");
    leave_loop(32'h1000_0040);
  endtask

  task automatic t_len1();
    run_loop(32'h0000_0200, 1, 4, 0, "R11");
    leave_loop(32'h0000_0200);
  endtask

  task automatic t_len_full();
    run_loop(32'h3000_0010, 32, 2, 0, "R11");
    leave_loop(32'h3000_0010);
  endtask

  task automatic t_len_guard();
    logic [31:0] s = 32'h0000_4000;
    fetch(s, 0, "R8", 1, s, 6'd33);
    fetch(s + 4, 0, "R8", 0, 0, 0);
    fetch(s, 0, "R8", 1, s, 6'd33);
    fetch(s + 4, 0, "R8", 0, 0, 0);
    fetch(s, 0, "R8", 1, s, 6'd0);
    fetch(s, 0, "R8", 1, s, 6'd0);
    fetch(s + 4, 0, "R8", 0, 0, 0);
    // oversize detect while serving drops to idle
    run_loop(s, 2, 2, 0, "R6");
    fetch(s, 0, "R8", 1, s, 6'd40);
    fetch(s + 4, 0, "R8", 0, 0, 0);
  endtask

  task automatic t_det_addr();
    logic [31:0] s = 32'h0000_0500;
    fetch(s, 0, "R4", 1, s, 6'd3);
    fetch(s + 4, 0, "R4", 0, 0, 0);
    fetch(s + 8, 0, "R8", 1, s, 6'd3);
    fetch(s, 0, "R8", 1, s, 6'd3);
    fetch(s + 4, 1, "R8", 0, 0, 0);
    fetch(s + 8, 1, "R8", 0, 0, 0);
    leave_loop(s);
  endtask

  task automatic t_abort_fill();
    logic [31:0] s = 32'h0000_0600;
    fetch(s, 0, "R4", 1, s, 6'd4);
    fetch(s + 4, 0, "R4", 0, 0, 0);
    fetch(s + 32'h100, 0, "R7", 0, 0, 0);
    fetch(s + 32'h104, 0, "R7", 0, 0, 0);
    fetch(s, 0, "R7", 1, s, 6'd4);
    fetch(s + 4, 0, "R7", 0, 0, 0);
    fetch(s + 8, 0, "R7", 0, 0, 0);
    fetch(s + 12, 0, "R7", 0, 0, 0);
    fetch(s, 0, "R5", 1, s, 6'd4);
    fetch(s + 4, 1, "R6", 0, 0, 0);
    leave_loop(s);
  endtask

  task automatic t_restart();
    logic [31:0] a = 32'h0000_0700;
    logic [31:0] b = 32'h0000_0780;
    run_loop(a, 3, 2, 0, "R6");
    fetch(b, 0, "R9", 1, b, 6'd2);
    fetch(b + 4, 0, "R9", 0, 0, 0);
    fetch(b, 0, "R9", 1, b, 6'd2);
    fetch(b + 4, 1, "R9", 0, 0, 0);
    fetch(b, 1, "R9", 1, b, 6'd2);
    fetch(b + 4, 1, "R9", 0, 0, 0);
    leave_loop(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_len1();
    t_len_full();
    t_len_guard();
    t_det_addr();
    t_abort_fill();
    t_restart();
    gap(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule